// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Arithmetic Flags

This block is the combinational arithmetic and logic unit of a small RISC integer datapath. It takes two operands, `a_i` and `b_i`, and a mode code that has already been decoded. In the same cycle it returns a result word, a carry flag and a signed overflow flag. It covers signed and unsigned add and subtract, the four bitwise operations AND, OR, XOR and NOR, and signed and unsigned set-less-than.

The datapath is a chain of identical one-bit slices with a rippling carry. Each slice contains a full adder with an optional inversion of B, followed by a result multiplexer. Subtraction inverts B in every slice and forces the carry into bit 0 to 1. The comparisons reuse this subtraction path. A small piece of logic at the top of the chain derives the overflow, the carry and the less-than bit. The less-than bit is fed back into bit 0 as that slice's result, and every other slice returns 0.

Top module: `bitslice_alu`

## Requirements
- R1: Mode 4'b0000 (signed add) and mode 4'b0001 (unsigned add) return (A + B) modulo 2^WIDTH. The carry output is the carry out of the top bit.
- R2: Mode 4'b0010 (signed subtract) and mode 4'b0011 (unsigned subtract) return (A − B) modulo 2^WIDTH. The carry output is the carry out of the top bit of A + ~B + 1, so it is 1 exactly when A ≥ B as unsigned numbers.
- R3: In modes 4'b0000 and 4'b0010, the overflow output is 1 exactly when the true signed result lies outside the two's complement range of WIDTH bits. This equals the carry into the top bit XOR the carry out of it.
- R4: Modes 4'b0001 and 4'b0011 never assert the overflow output, even when the signed result overflows.
- R5: Modes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 return A AND B, A OR B, A XOR B and NOR(A, B) respectively. In these modes the carry and overflow outputs are both 0.
- R6: Mode 4'b1010 (signed less-than) returns 1 when A < B as signed numbers and 0 otherwise. All upper result bits are 0, and carry and overflow are both 0. Two examples: 0x00000002 compared with 0x00000001 gives 0, and 0xFFFFFFFF compared with 0x00000001 gives 1.
- R7: Mode 4'b1011 (unsigned less-than) returns 1 when A < B as unsigned numbers and 0 otherwise. Carry and overflow are both 0. For example, 0xFFFFFFFF compared with 0x00000001 gives 0.
- R8: Any mode code not listed above returns a zero result with carry and overflow both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| mode_i | input | 4 | Decoded operation code |
| result_o | output | WIDTH | Operation result |
| carry_o | output | 1 | Carry out of the top bit (add and subtract modes only) |
| overflow_o | output | 1 | Signed overflow (signed add and subtract only) |

## Verification
The bench builds the ALU twice. The first instance uses WIDTH = 4 and is swept exhaustively over all 16 mode codes and all 256 operand pairs. This reaches every signed overflow boundary, every less-than outcome that differs between the signed and unsigned readings, and every unused code. The second instance uses the default WIDTH = 32 and runs directed vectors: the comparison examples from R6 and R7, overflow at the extremes of the full-width range, and carry out of an all-ones sum.

// File: rtl/bsalu_pkg.sv
`timescale 1ns/1ps
// Package bsalu_pkg
// Shared mode codes and per-slice result select codes for the bit-sliced ALU.
// Assumes the mode arrives already decoded as a 4-bit code.
package bsalu_pkg;

    // Operation codes presented on mode_i
    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_ADDU = 4'b0001,
        OP_SUB  = 4'b0010,
        OP_SUBU = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_NOR  = 4'b0111,
        OP_SLT  = 4'b1010,
        OP_SLTU = 4'b1011
    } alu_op_e;

    // Result source chosen inside every slice
    typedef enum logic [2:0] {
        SEL_ZERO = 3'd0,
        SEL_SUM  = 3'd1,
        SEL_AND  = 3'd2,
        SEL_OR   = 3'd3,
        SEL_XOR  = 3'd4,
        SEL_NOR  = 3'd5,
        SEL_LESS = 3'd6
    } slice_sel_e;

endpackage

// File: rtl/bsalu_ctrl.sv
`timescale 1ns/1ps
// Module bsalu_ctrl
// Turns the 4-bit mode into slice controls: B inversion, carry into bit 0,
// result select, and enables for the overflow, carry and compare logic at
// the top of the chain. Assumes unlisted codes must produce zero, no flags.
module bsalu_ctrl
    import bsalu_pkg::*;
(
    input  logic [3:0]  mode_i,
    output logic        invert_b_o,
    output logic        carry_in_o,
    output slice_sel_e  sel_o,
    output logic        ovf_en_o,
    output logic        cout_en_o,
    output logic        cmp_signed_o
);

    // Decode the operation code into datapath controls
    always_comb begin
        invert_b_o   = 1'b0;
        carry_in_o   = 1'b0;
        sel_o        = SEL_ZERO;
        ovf_en_o     = 1'b0;
        cout_en_o    = 1'b0;
        cmp_signed_o = 1'b0;
        case (mode_i)
            OP_ADD: begin
                sel_o     = SEL_SUM;
                ovf_en_o  = 1'b1;
                cout_en_o = 1'b1;
            end
            OP_ADDU: begin
                sel_o     = SEL_SUM;
                cout_en_o = 1'b1;
            end
            OP_SUB: begin
                invert_b_o = 1'b1;
                carry_in_o = 1'b1;
                sel_o      = SEL_SUM;
                ovf_en_o   = 1'b1;
                cout_en_o  = 1'b1;
            end
            OP_SUBU: begin
                invert_b_o = 1'b1;
                carry_in_o = 1'b1;
                sel_o      = SEL_SUM;
                cout_en_o  = 1'b1;
            end
            OP_AND: sel_o = SEL_AND;
            OP_OR:  sel_o = SEL_OR;
            OP_XOR: sel_o = SEL_XOR;
            OP_NOR: sel_o = SEL_NOR;
            OP_SLT: begin
                invert_b_o   = 1'b1;
                carry_in_o   = 1'b1;
                sel_o        = SEL_LESS;
                cmp_signed_o = 1'b1;
            end
            OP_SLTU: begin
                invert_b_o = 1'b1;
                carry_in_o = 1'b1;
                sel_o      = SEL_LESS;
            end
            default: sel_o = SEL_ZERO;
        endcase
    end

endmodule

// File: rtl/bsalu_slice.sv
`timescale 1ns/1ps
// Module bsalu_slice
// One bit of the ALU: a full adder with optional B inversion, plus a result
// multiplexer over sum, the bitwise functions and the injected less bit.
// Assumes less_i is tied to 0 on every slice except bit 0.
module bsalu_slice
    import bsalu_pkg::*;
(
    input  logic        a_i,
    input  logic        b_i,
    input  logic        invert_b_i,
    input  logic        cin_i,
    input  logic        less_i,
    input  slice_sel_e  sel_i,
    output logic        res_o,
    output logic        cout_o
);

    logic b_eff;
    logic half;
    logic sum;

    // Full adder on A and the possibly inverted B
    always_comb begin
        b_eff  = b_i ^ invert_b_i;
        half   = a_i ^ b_eff;
        sum    = half ^ cin_i;
        cout_o = (a_i & b_eff) | (cin_i & half);
    end

    // Pick the slice result from the selected source
    always_comb begin
        case (sel_i)
            SEL_SUM:  res_o = sum;
            SEL_AND:  res_o = a_i & b_i;
            SEL_OR:   res_o = a_i | b_i;
            SEL_XOR:  res_o = a_i ^ b_i;
            SEL_NOR:  res_o = ~(a_i | b_i);
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bsalu_flags.sv
`timescale 1ns/1ps
// Module bsalu_flags
// Logic at the top of the chain. It derives signed overflow from the carries
// around the top bit, gates the carry output, and forms the less-than bit
// for the signed and unsigned comparisons.
// Assumes the chain is performing A + ~B + 1 whenever a compare is selected.
module bsalu_flags (
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic invert_b_i,
    input  logic c_into_msb_i,
    input  logic c_out_msb_i,
    input  logic ovf_en_i,
    input  logic cout_en_i,
    input  logic cmp_signed_i,
    output logic overflow_o,
    output logic carry_o,
    output logic set_less_o
);

    logic ovf_raw;
    logic sum_msb;

    // Raw signed overflow and the top sum bit
    always_comb begin
        ovf_raw = c_into_msb_i ^ c_out_msb_i;
        sum_msb = a_msb_i ^ (b_msb_i ^ invert_b_i) ^ c_into_msb_i;
    end

    // Gate flags by mode and form the compare outcome
    always_comb begin
        overflow_o = ovf_en_i & ovf_raw;
        carry_o    = cout_en_i & c_out_msb_i;
        if (cmp_signed_i) set_less_o = sum_msb ^ ovf_raw;
        else              set_less_o = ~c_out_msb_i;
    end

endmodule

// File: rtl/bitslice_alu.sv
`timescale 1ns/1ps
// Module bitslice_alu
// Combinational ALU made of WIDTH one-bit slices with a rippling carry.
// The flag logic at the top slice feeds the less-than bit back into bit 0.
// Assumes WIDTH >= 2 and a decoded 4-bit mode.
module bitslice_alu
    import bsalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       mode_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             overflow_o
);

    localparam int MSB = WIDTH - 1;

    logic        invert_b;
    logic        carry_in;
    slice_sel_e  sel;
    logic        ovf_en;
    logic        cout_en;
    logic        cmp_signed;
    logic        set_less;
    logic [WIDTH:0] carry;

    bsalu_ctrl u_ctrl (
        .mode_i       (mode_i),
        .invert_b_o   (invert_b),
        .carry_in_o   (carry_in),
        .sel_o        (sel),
        .ovf_en_o     (ovf_en),
        .cout_en_o    (cout_en),
        .cmp_signed_o (cmp_signed)
    );

    // Carry into bit 0 comes from the decoded mode
    always_comb carry[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_in;
        if (i == 0) begin : g_lsb
            // Bit 0 carries the comparison outcome
            always_comb less_in = set_less;
        end else begin : g_upper
            // Upper bits return zero in compare modes
            always_comb less_in = 1'b0;
        end
        bsalu_slice u_slice (
            .a_i        (a_i[i]),
            .b_i        (b_i[i]),
            .invert_b_i (invert_b),
            .cin_i      (carry[i]),
            .less_i     (less_in),
            .sel_i      (sel),
            .res_o      (result_o[i]),
            .cout_o     (carry[i+1])
        );
    end

    bsalu_flags u_flags (
        .a_msb_i      (a_i[MSB]),
        .b_msb_i      (b_i[MSB]),
        .invert_b_i   (invert_b),
        .c_into_msb_i (carry[MSB]),
        .c_out_msb_i  (carry[WIDTH]),
        .ovf_en_i     (ovf_en),
        .cout_en_i    (cout_en),
        .cmp_signed_i (cmp_signed),
        .overflow_o   (overflow_o),
        .carry_o      (carry_o),
        .set_less_o   (set_less)
    );

    // Port-level checks of the flag rules, skipped while inputs are unknown
    always_comb begin
        if (!$isunknown({a_i, b_i, mode_i})) begin
            if (mode_i == OP_ADD)
                assert_ovf_add_R3: assert (overflow_o ==
                    ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                    else $error("R3 add overflow rule broken");
            if (mode_i == OP_SUB)
                assert_ovf_sub_R3: assert (overflow_o ==
                    ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                    else $error("R3 sub overflow rule broken");
            if (mode_i == OP_ADDU || mode_i == OP_SUBU)
                assert_no_overflow_R4: assert (!overflow_o)
                    else $error("R4 unsigned mode raised overflow");
            if (mode_i[3:2] == 2'b01)
                assert_logic_flags_R5: assert (!overflow_o && !carry_o)
                    else $error("R5 logical mode raised a flag");
            if (mode_i == OP_SLT || mode_i == OP_SLTU)
                assert_cmp_shape_R6: assert (result_o[MSB:1] == '0 && !overflow_o && !carry_o)
                    else $error("R6 compare result not 0 or 1");
            if (mode_i == OP_SLTU)
                assert_sltu_R7: assert (result_o[0] == (a_i < b_i))
                    else $error("R7 unsigned compare wrong");
            if (mode_i[3] && mode_i[2:1] != 2'b01)
                assert_unused_zero_R8: assert (result_o == '0 && !overflow_o && !carry_o)
                    else $error("R8 unused code not zero");
        end
    end

endmodule

// File: tb/bitslice_alu_tb.sv
`timescale 1ns/1ps
module bitslice_alu_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [3:0]  a4, b4, m4;
    logic [3:0]  r4;
    logic        c4, v4;
    logic [31:0] a32, b32;
    logic [3:0]  m32;
    logic [31:0] r32;
    logic        c32, v32;

    bitslice_alu #(.WIDTH(4)) u_dut (
        .a_i(a4), .b_i(b4), .mode_i(m4),
        .result_o(r4), .carry_o(c4), .overflow_o(v4)
    );

    bitslice_alu #(.WIDTH(32)) u_dut_wide (
        .a_i(a32), .b_i(b32), .mode_i(m32),
        .result_o(r32), .carry_o(c32), .overflow_o(v32)
    );

    // Arithmetic reference for width w
    function automatic void model(input int w, input logic [3:0] m,
                                  input logic [31:0] ai, input logic [31:0] bi,
                                  output logic [31:0] r, output logic c, output logic v);
        longint unsigned mask, a, b, full;
        longint sa, sb, t, lo, hi;
        mask = (64'd1 << w) - 64'd1;
        a = longint'(ai) & mask;
        b = longint'(bi) & mask;
        sa = ((a >> (w-1)) & 1) != 0 ? longint'(a) - longint'(64'd1 << w) : longint'(a);
        sb = ((b >> (w-1)) & 1) != 0 ? longint'(b) - longint'(64'd1 << w) : longint'(b);
        hi = longint'(64'd1 << (w-1)) - 1;
        lo = -longint'(64'd1 << (w-1));
        r = '0; c = 1'b0; v = 1'b0;
        case (m)
            4'd0, 4'd1: begin
                full = a + b;
                r = 32'(full & mask);
                c = ((full >> w) & 1) != 0;
                t = sa + sb;
                if (m == 4'd0) v = (t > hi) || (t < lo);
            end
            4'd2, 4'd3: begin
                full = a + ((~b) & mask) + 64'd1;
                r = 32'(full & mask);
                c = ((full >> w) & 1) != 0;
                t = sa - sb;
                if (m == 4'd2) v = (t > hi) || (t < lo);
            end
            4'd4: r = 32'(a & b);
            4'd5: r = 32'(a | b);
            4'd6: r = 32'(a ^ b);
            4'd7: r = 32'((~(a | b)) & mask);
            4'd10: r = (sa < sb) ? 32'd1 : 32'd0;
            4'd11: r = (a < b) ? 32'd1 : 32'd0;
            default: r = '0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] m);
        case (m)
            4'd0:  return "R1/R3";
            4'd1:  return "R1/R4";
            4'd2:  return "R2/R3";
            4'd3:  return "R2/R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R5";
            4'd10: return "R6";
            4'd11: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string req, input logic [31:0] got_r, input logic got_c,
                           input logic got_v, input logic [31:0] exp_r, input logic exp_c,
                           input logic exp_v);
        n_checks++;
        if (got_r !== exp_r || got_c !== exp_c || got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual r=%h c=%b v=%b expected r=%h c=%b v=%b",
                     req, got_r, got_c, got_v, exp_r, exp_c, exp_v);
        end
    endtask

    // Drive narrow instance at posedge, compare at negedge
    task automatic run4(input logic [3:0] m, input logic [3:0] a, input logic [3:0] b);
        logic [31:0] er; logic ec, ev;
        @(posedge clk);
        m4 = m; a4 = a; b4 = b;
        @(negedge clk);
        model(4, m, {28'd0, a}, {28'd0, b}, er, ec, ev);
        compare(tag(m), {28'd0, r4}, c4, v4, er, ec, ev);
    endtask

    task automatic run32(input string req, input logic [3:0] m,
                         input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er; logic ec, ev;
        @(posedge clk);
        m32 = m; a32 = a; b32 = b;
        @(negedge clk);
        model(32, m, a, b, er, ec, ev);
        compare(req, r32, c32, v32, er, ec, ev);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        a4 = '0; b4 = '0; m4 = '0;
        a32 = '0; b32 = '0; m32 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state after reset: zero operands in add mode give all zeros (R1)
        compare("R1 idle", r32, c32, v32, 32'd0, 1'b0, 1'b0);

        // Spot checks against fixed expectations (R6, R7, R3, R1)
        run32("R6 slt 2<1", 4'b1010, 32'h2, 32'h1);
        compare("R6 slt 2<1 fixed", r32, c32, v32, 32'd0, 1'b0, 1'b0);
        run32("R6 slt -1<1", 4'b1010, 32'hFFFF_FFFF, 32'h1);
        compare("R6 slt -1<1 fixed", r32, c32, v32, 32'd1, 1'b0, 1'b0);
        run32("R7 sltu -1<1", 4'b1011, 32'hFFFF_FFFF, 32'h1);
        compare("R7 sltu fixed", r32, c32, v32, 32'd0, 1'b0, 1'b0);
        run32("R7 sltu 1<max", 4'b1011, 32'h1, 32'hFFFF_FFFF);
        run32("R3 add max+1", 4'b0000, 32'h7FFF_FFFF, 32'h1);
        compare("R3 add max+1 fixed", r32, c32, v32, 32'h8000_0000, 1'b0, 1'b1);
        run32("R4 addu max+1", 4'b0001, 32'h7FFF_FFFF, 32'h1);
        run32("R3 sub min-1", 4'b0010, 32'h8000_0000, 32'h1);
        run32("R4 subu min-1", 4'b0011, 32'h8000_0000, 32'h1);
        run32("R1 addu carry", 4'b0001, 32'hFFFF_FFFF, 32'h1);
        compare("R1 addu carry fixed", r32, c32, v32, 32'd0, 1'b1, 1'b0);
        run32("R2 sub equal", 4'b0010, 32'h1234_5678, 32'h1234_5678);
        run32("R2 subu borrow", 4'b0011, 32'h1, 32'h2);
        run32("R6 slt min<max", 4'b1010, 32'h8000_0000, 32'h7FFF_FFFF);
        run32("R5 nor", 4'b0111, 32'hF0F0_0000, 32'h0000_FF00);
        run32("R5 xor", 4'b0110, 32'hDEAD_BEEF, 32'hFFFF_0000);
        run32("R8 unused", 4'b1111, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // Exhaustive sweep of the 4-bit instance over every mode and operand pair
        for (int m = 0; m < 16; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(4'(m), 4'(a), 4'(b));

        summary();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule